// File: doc/BRIEF.md
# Programmed I/O Instruction Executor

This unit sits in a processor core beside the arithmetic datapath. It carries out the input/output class of 16-bit instructions. The core hands it an instruction word, the current contents of the four accumulators and the program counter. The executor then runs one transaction on the peripheral bus. The bus carries a six-bit device number, a selector for one of three device data registers, read and write strobes, outgoing data, and three command strobes (start, clear, pulse). The executor also samples the addressed device's busy and done flags.

A three-bit transfer field in the instruction picks the operation. It is one of six register moves (input or output on register A, B or C), a command-only operation, or a status test. For the moves and the command-only operation, a two-bit control field issues at most one command strobe alongside the transfer. For the status test, that same field instead picks which of four conditions makes the program counter skip one instruction.

Each accepted instruction takes two cycles. In the first cycle the unit drives the bus. In the second it reports completion, the accumulator write-back and the next program counter. Any word whose leading bits do not mark it as an I/O instruction is rejected with an illegal flag.

Top module: `pio_exec`

## Requirements
- R1: A word is legal only when instr[15:13] equals 3'b011. An illegal word that is accepted raises `done` and `illegal` together for one cycle, in the cycle after acceptance. That word drives no bus strobe, `dev_rd` or `dev_wr` at any time, and leaves `acc_we` and `pc_we` low.
- R2: A legal word accepted at clock edge N drives the bus only in the cycle that follows edge N. It raises `done` (with `illegal` low) only in the cycle that follows edge N+1. `done` is never high in two consecutive cycles, and the bus is quiet while `done` is high.
- R3: Field layout: instr[12:11] is the accumulator number, instr[10:8] the transfer code, instr[7:6] the control field and instr[5:0] the device number. During the bus cycle, `dev_code` equals instr[5:0]. For a data move, `dev_rsel` is 0 for register A (codes 001/010), 1 for B (011/100) and 2 for C (101/110).
- R4: Transfer codes 001, 011 and 101 are inputs. `dev_rd` is high during the bus cycle. The `dev_rdata` value present in that cycle appears on `acc_wdata` in the completion cycle, with `acc_we` high and `acc_idx` set to the accumulator number.
- R5: Transfer codes 010, 100 and 110 are outputs. `dev_wr` is high during the bus cycle. `dev_wdata` equals the selected accumulator as it stood at acceptance, even if `acc_in` changes afterwards.
- R6: For every transfer code except 111, the control field issues a command: 00 none, 01 `stb_start`, 10 `stb_clear`, 11 `stb_pulse`. The strobe lasts for the bus cycle only, and at most one strobe is ever high.
- R7: With transfer code 111, no strobe, read or write is issued. `dev_busy` and `dev_done` are sampled in the bus cycle. The control field picks the skip condition: 00 busy set, 01 busy clear, 10 done set, 11 done clear.
- R8: In the completion cycle of a legal word, `pc_we` is high. `next_pc` is the PC captured at acceptance plus 2 when a skip is taken, and plus 1 otherwise, modulo 2^PCW. For an illegal word, `next_pc` equals the captured PC and `pc_we` stays low.
- R9: `acc_we` is high only in the completion cycle of an input transfer. Output, command-only (000) and skip (111) words never write an accumulator.
- R10: `instr_valid` is ignored while an instruction is in progress. A word offered during the bus or completion cycle neither alters the current result nor starts a later transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered this cycle |
| instr | input | 16 | Instruction word |
| acc_in | input | NACC x DW | Current accumulator contents |
| pc_in | input | PCW | Current program counter |
| dev_code | output | 6 | Addressed device number |
| dev_rsel | output | 2 | Device data register select (0 A, 1 B, 2 C) |
| dev_rd | output | 1 | Read strobe |
| dev_wr | output | 1 | Write strobe |
| dev_wdata | output | DW | Data to the device |
| dev_rdata | input | DW | Data from the device |
| dev_busy | input | 1 | Device busy flag |
| dev_done | input | 1 | Device done flag |
| stb_start | output | 1 | Start command strobe |
| stb_clear | output | 1 | Clear command strobe |
| stb_pulse | output | 1 | Pulse command strobe |
| acc_we | output | 1 | Accumulator write enable |
| acc_idx | output | 2 | Accumulator being written |
| acc_wdata | output | DW | Accumulator write data |
| pc_we | output | 1 | Program counter update enable |
| next_pc | output | PCW | Next program counter |
| done | output | 1 | Instruction complete |
| illegal | output | 1 | Word rejected as not an I/O instruction |

## Verification
A wrong sequencer state shows within one or two cycles of acceptance. The symptoms are a strobe in the completion cycle, a missing or doubled `done`, or a second transaction started by a word offered mid-flight. A wrong latched field or operand shows in the bus cycle itself, as the wrong device, register select, write data or command strobe. A mis-captured read value or status bit only shows one cycle later, as a wrong `acc_wdata` or a `next_pc` that is off by one. For that reason every completion cycle is compared against a skip table and a PC step that the bench computes on its own.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int IW   = 16;
  localparam int DEVW = 6;
  localparam int ACCW = 2;
  localparam int CTLW = 2;
  localparam int XFW  = 3;
  localparam logic [2:0] IO_PREFIX = 3'b011;

  typedef enum logic [1:0] {K_NONE, K_IN, K_OUT, K_SKIP} kind_t;
  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_FIN, S_BAD} st_t;

  typedef struct packed {
    logic start;
    logic clear;
    logic pulse;
  } cmd_t;

  typedef struct packed {
    logic            legal;
    logic [ACCW-1:0] acc;
    kind_t           kind;
    logic [1:0]      rsel;
    logic [CTLW-1:0] ctl;
    logic [DEVW-1:0] dev;
  } dec_t;

  function automatic logic f_is_io(input logic [IW-1:0] w);
    return w[IW-1 -: 3] == IO_PREFIX;
  endfunction

  function automatic kind_t f_kind(input logic [XFW-1:0] x);
    if (x == 3'b000) return K_NONE;
    if (x == 3'b111) return K_SKIP;
    return x[0] ? K_IN : K_OUT;
  endfunction

  // codes 1..6 pair up as (A,A),(B,B),(C,C): (x-1)>>1 gives the register
  function automatic logic [1:0] f_rsel(input logic [XFW-1:0] x);
    logic [XFW-1:0] t;
    t = x - 3'd1;
    return t[2:1];
  endfunction

  function automatic cmd_t f_cmd(input kind_t k, input logic [CTLW-1:0] c);
    cmd_t r;
    r = '0;
    if (k != K_SKIP) begin
      case (c)
        2'b01:   r.start = 1'b1;
        2'b10:   r.clear = 1'b1;
        2'b11:   r.pulse = 1'b1;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic f_skip(input logic [CTLW-1:0] c, input logic busy,
                                  input logic dn);
    case (c)
      2'b00:   return busy;
      2'b01:   return !busy;
      2'b10:   return dn;
      default: return !dn;
    endcase
  endfunction

  function automatic dec_t f_decode(input logic [IW-1:0] w);
    dec_t d;
    d.legal = f_is_io(w);
    d.acc   = w[12:11];
    d.kind  = f_kind(w[10:8]);
    d.rsel  = f_rsel(w[10:8]);
    d.ctl   = w[7:6];
    d.dev   = w[5:0];
    return d;
  endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  always_comb dec_o = f_decode(instr_i);
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PCW  = 15,
  parameter int NACC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  dec_t                      dec_i,
  input  logic [NACC-1:0][DW-1:0]   acc_i,
  input  logic [PCW-1:0]            pc_i,
  output st_t                       st_o,
  output kind_t                     kind_o,
  output logic [ACCW-1:0]           acc_o,
  output logic [1:0]                rsel_o,
  output logic [CTLW-1:0]           ctl_o,
  output logic [DEVW-1:0]           dev_o,
  output logic [DW-1:0]             opnd_o,
  output logic [PCW-1:0]            pc_o,
  output logic                      accept_o
);
  st_t st_q;

  assign accept_o = in_valid && (st_q == S_IDLE);
  assign st_o     = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_o <= K_NONE;
      acc_o  <= '0;
      rsel_o <= '0;
      ctl_o  <= '0;
      dev_o  <= '0;
      opnd_o <= '0;
      pc_o   <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (accept_o) begin
            st_q   <= dec_i.legal ? S_DRIVE : S_BAD;
            kind_o <= dec_i.kind;
            acc_o  <= dec_i.acc;
            rsel_o <= dec_i.rsel;
            ctl_o  <= dec_i.ctl;
            dev_o  <= dec_i.dev;
            opnd_o <= acc_i[dec_i.acc];
            pc_o   <= pc_i;
          end
        end
        S_DRIVE: st_q <= S_FIN;
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_bus.sv
module pio_bus
  import pio_pkg::*;
#(
  parameter int DW = 16
) (
  input  st_t             st_i,
  input  kind_t           kind_i,
  input  logic [1:0]      rsel_i,
  input  logic [CTLW-1:0] ctl_i,
  input  logic [DEVW-1:0] dev_i,
  input  logic [DW-1:0]   opnd_i,
  output logic [DEVW-1:0] dev_code_o,
  output logic [1:0]      dev_rsel_o,
  output logic            dev_rd_o,
  output logic            dev_wr_o,
  output logic [DW-1:0]   dev_wdata_o,
  output cmd_t            cmd_o
);
  logic active;
  assign active = (st_i == S_DRIVE);

  always_comb begin
    dev_code_o  = '0;
    dev_rsel_o  = '0;
    dev_rd_o    = 1'b0;
    dev_wr_o    = 1'b0;
    dev_wdata_o = '0;
    cmd_o       = '0;
    if (active) begin
      dev_code_o = dev_i;
      cmd_o      = f_cmd(kind_i, ctl_i);
      if (kind_i == K_IN || kind_i == K_OUT) dev_rsel_o = rsel_i;
      if (kind_i == K_IN) dev_rd_o = 1'b1;
      if (kind_i == K_OUT) begin
        dev_wr_o    = 1'b1;
        dev_wdata_o = opnd_i;
      end
    end
  end
endmodule

// File: rtl/pio_wb.sv
module pio_wb
  import pio_pkg::*;
#(
  parameter int DW  = 16,
  parameter int PCW = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  st_t             st_i,
  input  kind_t           kind_i,
  input  logic [ACCW-1:0] acc_i,
  input  logic [CTLW-1:0] ctl_i,
  input  logic [PCW-1:0]  pc_i,
  input  logic [DW-1:0]   dev_rdata_i,
  input  logic            dev_busy_i,
  input  logic            dev_done_i,
  output logic            done_o,
  output logic            illegal_o,
  output logic            acc_we_o,
  output logic [ACCW-1:0] acc_idx_o,
  output logic [DW-1:0]   acc_wdata_o,
  output logic            pc_we_o,
  output logic [PCW-1:0]  next_pc_o,
  output logic            skip_o
);
  logic [DW-1:0] rdata_q;
  logic          busy_q;
  logic          dn_q;

  function automatic logic [PCW-1:0] f_step(input logic [PCW-1:0] pc, input logic sk);
    return pc + (sk ? PCW'(2) : PCW'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      busy_q  <= 1'b0;
      dn_q    <= 1'b0;
    end else if (st_i == S_DRIVE) begin
      rdata_q <= dev_rdata_i;
      busy_q  <= dev_busy_i;
      dn_q    <= dev_done_i;
    end
  end

  always_comb begin
    done_o      = 1'b0;
    illegal_o   = 1'b0;
    acc_we_o    = 1'b0;
    acc_idx_o   = '0;
    acc_wdata_o = '0;
    pc_we_o     = 1'b0;
    next_pc_o   = '0;
    skip_o      = 1'b0;
    case (st_i)
      S_FIN: begin
        done_o    = 1'b1;
        pc_we_o   = 1'b1;
        skip_o    = (kind_i == K_SKIP) && f_skip(ctl_i, busy_q, dn_q);
        next_pc_o = f_step(pc_i, skip_o);
        if (kind_i == K_IN) begin
          acc_we_o    = 1'b1;
          acc_idx_o   = acc_i;
          acc_wdata_o = rdata_q;
        end
      end
      S_BAD: begin
        done_o    = 1'b1;
        illegal_o = 1'b1;
        next_pc_o = pc_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pio_exec.sv
module pio_exec
  import pio_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PCW  = 15,
  parameter int NACC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    instr_valid,
  input  logic [15:0]             instr,
  input  logic [NACC-1:0][DW-1:0] acc_in,
  input  logic [PCW-1:0]          pc_in,
  output logic [5:0]              dev_code,
  output logic [1:0]              dev_rsel,
  output logic                    dev_rd,
  output logic                    dev_wr,
  output logic [DW-1:0]           dev_wdata,
  input  logic [DW-1:0]           dev_rdata,
  input  logic                    dev_busy,
  input  logic                    dev_done,
  output logic                    stb_start,
  output logic                    stb_clear,
  output logic                    stb_pulse,
  output logic                    acc_we,
  output logic [1:0]              acc_idx,
  output logic [DW-1:0]           acc_wdata,
  output logic                    pc_we,
  output logic [PCW-1:0]          next_pc,
  output logic                    done,
  output logic                    illegal
);
  dec_t            dec;
  st_t             st;
  kind_t           kind_q;
  logic [ACCW-1:0] acc_q;
  logic [1:0]      rsel_q;
  logic [CTLW-1:0] ctl_q;
  logic [DEVW-1:0] dev_q;
  logic [DW-1:0]   opnd_q;
  logic [PCW-1:0]  pc_q;
  cmd_t            cmd;

  // named internal events for the checker
  logic ev_accept;
  logic ev_skip_taken;

  pio_decode u_dec (.instr_i(instr), .dec_o(dec));

  pio_seq #(.DW(DW), .PCW(PCW), .NACC(NACC)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(instr_valid), .dec_i(dec),
    .acc_i(acc_in), .pc_i(pc_in), .st_o(st), .kind_o(kind_q),
    .acc_o(acc_q), .rsel_o(rsel_q), .ctl_o(ctl_q), .dev_o(dev_q),
    .opnd_o(opnd_q), .pc_o(pc_q), .accept_o(ev_accept)
  );

  pio_bus #(.DW(DW)) u_bus (
    .st_i(st), .kind_i(kind_q), .rsel_i(rsel_q), .ctl_i(ctl_q),
    .dev_i(dev_q), .opnd_i(opnd_q), .dev_code_o(dev_code),
    .dev_rsel_o(dev_rsel), .dev_rd_o(dev_rd), .dev_wr_o(dev_wr),
    .dev_wdata_o(dev_wdata), .cmd_o(cmd)
  );

  assign stb_start = cmd.start;
  assign stb_clear = cmd.clear;
  assign stb_pulse = cmd.pulse;

  pio_wb #(.DW(DW), .PCW(PCW)) u_wb (
    .clk(clk), .rst_n(rst_n), .st_i(st), .kind_i(kind_q), .acc_i(acc_q),
    .ctl_i(ctl_q), .pc_i(pc_q), .dev_rdata_i(dev_rdata),
    .dev_busy_i(dev_busy), .dev_done_i(dev_done), .done_o(done),
    .illegal_o(illegal), .acc_we_o(acc_we), .acc_idx_o(acc_idx),
    .acc_wdata_o(acc_wdata), .pc_we_o(pc_we), .next_pc_o(next_pc),
    .skip_o(ev_skip_taken)
  );
endmodule

// File: rtl/pio_exec_chk.sv
module pio_exec_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    prefix,
  input logic          ev_accept,
  input logic          ev_skip_taken,
  input logic          dev_rd,
  input logic          dev_wr,
  input logic [DW-1:0] dev_rdata,
  input logic          stb_start,
  input logic          stb_clear,
  input logic          stb_pulse,
  input logic          acc_we,
  input logic [DW-1:0] acc_wdata,
  input logic          pc_we,
  input logic          done,
  input logic          illegal
);
  logic bus_act;
  assign bus_act = dev_rd || dev_wr || stb_start || stb_clear || stb_pulse;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_start, stb_clear, stb_pulse})); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr)); // R4
  AST_BUS_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |=> (done && !illegal)); // R2
  AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_act); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !acc_we && !pc_we)); // R1
  AST_BAD_PREFIX_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && prefix != 3'b011) |=> illegal); // R1
  AST_READ_TO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |=> (acc_we && acc_wdata == $past(dev_rdata))); // R4
  AST_WRITE_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |=> !acc_we); // R9
  AST_SKIP_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip_taken |-> (done && pc_we && !acc_we)); // R7
  AST_NO_BACK_TO_BACK_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ev_accept); // R10
endmodule

bind pio_exec pio_exec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prefix(instr[15:13]), .ev_accept(ev_accept),
  .ev_skip_taken(ev_skip_taken), .dev_rd(dev_rd), .dev_wr(dev_wr),
  .dev_rdata(dev_rdata), .stb_start(stb_start), .stb_clear(stb_clear),
  .stb_pulse(stb_pulse), .acc_we(acc_we), .acc_wdata(acc_wdata),
  .pc_we(pc_we), .done(done), .illegal(illegal)
);

// File: tb/sim_pio_exec.sv
module sim_pio_exec;
  localparam int DW = 16, PCW = 15, NACC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic                    instr_valid = 1'b0;
  logic [15:0]             instr = '0;
  logic [NACC-1:0][DW-1:0] acc_in = '0;
  logic [PCW-1:0]          pc_in = '0;
  logic [DW-1:0]           dev_rdata = '0;
  logic                    dev_busy = 1'b0, dev_done = 1'b0;
  logic [5:0]              dev_code;
  logic [1:0]              dev_rsel, acc_idx;
  logic                    dev_rd, dev_wr, stb_start, stb_clear, stb_pulse;
  logic                    acc_we, pc_we, done, illegal;
  logic [DW-1:0]           dev_wdata, acc_wdata;
  logic [PCW-1:0]          next_pc;

  pio_exec #(.DW(DW), .PCW(PCW), .NACC(NACC)) u0 (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit e_skip(input logic [1:0] c, input logic b, input logic d);
    return c[1] ? (d ^ c[0]) : (b ^ c[0]);
  endfunction

  function automatic logic [PCW-1:0] e_pc(input logic [PCW-1:0] pc, input bit sk);
    int unsigned v;
    v = int'(pc) + (sk ? 2 : 1);
    return PCW'(v % (1 << PCW));
  endfunction

  function automatic logic [4:0] quiet();
    return {dev_rd, dev_wr, stb_start, stb_clear, stb_pulse};
  endfunction

  // Runs one word; caller holds acc_in/pc_in/dev_* already set, at a negedge.
  task automatic run_one(input logic [15:0] w, input bit overlap);
    logic [2:0] xf; logic [1:0] ctl, a; logic [5:0] dv;
    logic [DW-1:0] av, rv; logic [PCW-1:0] pv; logic b, d;
    bit is_in, is_out, sk;
    xf = w[10:8]; ctl = w[7:6]; a = w[12:11]; dv = w[5:0];
    av = acc_in[a]; rv = dev_rdata; pv = pc_in; b = dev_busy; d = dev_done;
    is_in  = (xf == 3'd1 || xf == 3'd3 || xf == 3'd5);
    is_out = (xf == 3'd2 || xf == 3'd4 || xf == 3'd6);
    instr = w; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    if (w[15:13] != 3'b011) begin
      chk("R1 illegal flag", {done, illegal}, 2'b11);
      chk("R1 no bus activity", quiet(), 5'b0);
      chk("R1 no updates", {acc_we, pc_we}, 2'b00);
      chk("R8 illegal keeps pc", next_pc, pv);
      @(negedge clk);
      chk("R2 done single cycle", {done, quiet()}, 6'b0);
      return;
    end
    // bus cycle
    chk("R2 no done in bus cycle", done, 1'b0);
    chk("R3 device code", dev_code, dv);
    if (is_in || is_out) chk("R3 register select", dev_rsel, 32'((xf - 3'd1) >> 1));
    chk("R4 read strobe", dev_rd, is_in);
    chk("R5 write strobe", dev_wr, is_out);
    if (is_out) chk("R5 write data", dev_wdata, av);
    if (xf == 3'b111) chk("R7 no strobes on skip", quiet(), 5'b0);
    else chk("R6 command strobes", {stb_start, stb_clear, stb_pulse},
             {ctl == 2'b01, ctl == 2'b10, ctl == 2'b11});
    acc_in = ~acc_in; pc_in = ~pc_in;     // must not matter after acceptance
    if (overlap) begin
      instr = 16'h6041; instr_valid = 1'b1; // NIO with start, dev 1
    end
    @(negedge clk);
    instr_valid = 1'b0;
    sk = (xf == 3'b111) && e_skip(ctl, b, d);
    chk("R2 done after bus cycle", {done, illegal}, 2'b10);
    chk("R2 bus quiet at done", quiet(), 5'b0);
    chk("R9 accumulator write enable", acc_we, is_in);
    if (is_in) begin
      chk("R4 read data to acc", acc_wdata, rv);
      chk("R4 acc index", acc_idx, a);
    end
    chk("R8 pc write enable", pc_we, 1'b1);
    if (xf == 3'b111) chk("R7 skip next pc", next_pc, e_pc(pv, sk));
    else chk("R8 next pc", next_pc, e_pc(pv, 1'b0));
    @(negedge clk);
    if (overlap) chk("R10 offered word ignored", {done, quiet()}, 6'b0);
    else chk("R2 done single cycle", done, 1'b0);
  endtask

  task automatic set_ctx(input logic [PCW-1:0] p, input logic b, input logic d);
    for (int k = 0; k < NACC; k++) acc_in[k] = DW'($urandom);
    dev_rdata = DW'($urandom);
    pc_in = p; dev_busy = b; dev_done = d;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_bad++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R2 reset state", {done, illegal, acc_we, pc_we, quiet()}, 9'b0);
    chk("R3 reset device code", dev_code, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // every transfer code with every control value
    for (int x = 0; x < 8; x++)
      for (int c = 0; c < 4; c++) begin
        set_ctx(PCW'($urandom), 1'($urandom), 1'($urandom));
        run_one({3'b011, 2'(x + c), 3'(x), 2'(c), 6'($urandom)}, 1'b0);
      end
    // full skip table (R7)
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++) begin
        set_ctx(PCW'(100 + s), s[1], s[0]);
        run_one({3'b011, 2'b00, 3'b111, 2'(c), 6'd10}, 1'b0);
      end
    // PC wrap with and without skip (R8)
    set_ctx('1, 1'b1, 1'b0);
    run_one({3'b011, 2'b01, 3'b111, 2'b00, 6'd33}, 1'b0);
    set_ctx('1, 1'b1, 1'b0);
    run_one({3'b011, 2'b01, 3'b111, 2'b01, 6'd33}, 1'b0);
    // illegal words (R1)
    set_ctx(PCW'(50), 1'b0, 1'b0); run_one(16'h0000, 1'b0);
    set_ctx(PCW'(51), 1'b1, 1'b1); run_one(16'hFFFF, 1'b0);
    set_ctx(PCW'(52), 1'b0, 1'b1); run_one(16'h4141, 1'b0);
    // words offered mid-flight (R10)
    set_ctx(PCW'(7), 1'b0, 1'b0); run_one(16'h6A59, 1'b1);
    set_ctx(PCW'(8), 1'b1, 1'b0); run_one(16'h6F0C, 1'b1);
    // constrained random
    for (int i = 0; i < 500; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom % 5 != 0) w[15:13] = 3'b011;
      set_ctx(PCW'($urandom), 1'($urandom), 1'($urandom));
      run_one(w, ($urandom % 8) == 0);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule